// File: doc/BRIEF.md
# Three-Output Clock Gating and Divide Controller

This block is the digital back end of a three-output clock synthesizer. Each output picks one source clock: the buffered reference or one of three PLL clocks. It divides that clock by a programmable integer and then passes it through a gate that can only stop or start at a clean point in the waveform. A single multi-function control pin steers the outputs. A two-bit mode field decides what the pin means: drive enable, power-down, alternate divide for output A, or suspend of a chosen subset of outputs.

The configuration word is captured only while reset is held, and the design does not react to later changes of that word. All control decisions are made in the reference-clock domain. The enable for each output and the alternate-divide select for output A cross into the output's own source domain through synchronizers. After reset, and again after every power-down, a lock-wait counter clocked by the reference holds every output low. During that wait the busy flag and, in power-down, a PLL power-down request are raised.

Configuration word layout (55 bits with the defaults):
- mode in bits 1:0, encoded 0 drive enable, 1 power-down, 2 frequency select, 3 suspend
- suspend mask in bits 4:2, with bit 2+i belonging to output i
- lock-wait length in bits 16:5
- output i (i = 0, 1, 2) at base 17+10*i: source select in bits base+1:base, divide value in bits base+9:base+2
- alternate divide for output A (output 0) in bits 54:47

Top module: `clkgen_out_ctrl`

## Requirements
- R1: The configuration word is sampled only while reset is held. The mode field encoding is 0 drive enable, 1 power-down, 2 frequency select and 3 suspend, and it fixes the meaning of the control pin until the next reset.
- R2: In drive-enable mode (pin active high) all three drive-enable flags clear together when the pin is low and set together when it is high, and the clocks keep running either way. The flags follow a pin change after the third rising reference edge. In every other mode the flags are all set from the first functional cycle on.
- R3: In power-down mode (pin active low) a low pin raises the PLL power-down request with the same three-edge latency and stops every output low. In other modes the request is never raised after reset.
- R4: Busy equals the power-down request OR a nonzero lock counter. The counter loads the lock-wait length on each cycle the request is up, and counts down by one per reference cycle otherwise. No output has a rising edge while busy, and the outputs resume after busy falls. The same lock wait runs after reset.
- R5: In frequency-select mode a high pin makes output A use the alternate divide value. Outputs B and C are unaffected.
- R6: In suspend mode (pin active low) a low pin stops low exactly the outputs whose mask bit is set. The others keep running, and the stopped ones resume when the pin returns high.
- R7: Source select per output: 0 reference, 1 PLL clock 0, 2 PLL clock 1, 3 PLL clock 2.
- R8: With divide value N the output period is N source periods and the high time is floor(N/2) source periods. N=1 passes the source through, and N=0 behaves as N=1.
- R9: Stopping and starting are glitch-free: every high pulse has the full configured width, and a stopped output rests low.
- R10: While reset is held all outputs are low, the drive-enable flags are clear, and both the PLL power-down request and busy are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Buffered reference clock, control domain |
| pll_clk_i | input | 3 | PLL output clocks 0..2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pin_i | input | 1 | Multi-function control pin, asynchronous |
| cfg_i | input | 55 | Static configuration word, sampled in reset |
| clk_o | output | 3 | Gated, divided output clocks A, B, C |
| drv_en_o | output | 3 | Per-output drive enable (low means high impedance) |
| pll_pd_o | output | 1 | PLL power-down request |
| busy_o | output | 1 | Lock wait or power-down in progress |

## Verification
The assertions assume the configuration word is constant after reset release. They also assume the control pin is sampled only through the synchronizer, so the reference-domain relations hold cycle by cycle. The stimulus sets each configuration before reset asserts and never touches it afterwards. It changes the pin only on falling reference edges, and it drives the PLL clocks at a 50% duty cycle so that the expected pulse widths are exact. Clock-domain effects of gating are judged only after settling windows longer than the synchronizer path, and the pulse-width monitor is switched off around reset and around the divide switch on output A.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  typedef enum logic [1:0] {
    CTL_OE    = 2'd0,
    CTL_PWRDN = 2'd1,
    CTL_FSEL  = 2'd2,
    CTL_SUSP  = 2'd3
  } ctl_mode_e;
endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int NOUT        = 3,
  parameter int LOCK_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  ctl_mode_e         mode_i,
  input  logic [NOUT-1:0]   susp_mask_i,
  input  logic [LOCK_W-1:0] lock_len_i,
  output logic [NOUT-1:0]   drv_en_o,
  output logic              pll_pd_o,
  output logic              busy_o,
  output logic [NOUT-1:0]   run_o,
  output logic              alt_o,
  output logic [LOCK_W-1:0] lock_cnt_o
);
  logic              pin_s;
  logic              pd_q, pd_d;
  logic [LOCK_W-1:0] cnt_q, cnt_d;
  logic [NOUT-1:0]   drv_q, drv_d;
  logic [NOUT-1:0]   run_q, run_d;
  logic              alt_q, alt_d;
  logic              busy;
  logic              susp_hit;

  clkgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(ref_clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
  );

  assign busy = pd_q | (cnt_q != '0);

  always_comb begin
    pd_d     = (mode_i == CTL_PWRDN) & ~pin_s;
    alt_d    = (mode_i == CTL_FSEL) & pin_s;
    drv_d    = {NOUT{(mode_i != CTL_OE) | pin_s}};
    susp_hit = (mode_i == CTL_SUSP) & ~pin_s;
    if (pd_q)              cnt_d = lock_len_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
    for (int i = 0; i < NOUT; i++) begin
      run_d[i] = ~busy & ~(susp_hit & susp_mask_i[i]);
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q  <= 1'b1;
      cnt_q <= '0;
      drv_q <= '0;
      run_q <= '0;
      alt_q <= 1'b0;
    end else begin
      pd_q  <= pd_d;
      cnt_q <= cnt_d;
      drv_q <= drv_d;
      run_q <= run_d;
      alt_q <= alt_d;
    end
  end

  assign drv_en_o   = drv_q;
  assign pll_pd_o   = pd_q;
  assign busy_o     = busy;
  assign run_o      = run_q;
  assign alt_o      = alt_q;
  assign lock_cnt_o = cnt_q;
endmodule

// File: rtl/clkgen_out_path.sv
module clkgen_out_path #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             alt_i,
  input  logic [DIV_W-1:0] div_main_i,
  input  logic [DIV_W-1:0] div_alt_i,
  output logic             clk_o
);
  logic             rst_loc_n;
  logic             run_s;
  logic             alt_s;
  logic [DIV_W-1:0] div_sel, n_eff, half;
  logic             bypass;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             lvl_now;
  logic             en_q;

  clkgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(src_clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_loc_n)
  );
  clkgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_run_sync (
    .clk(src_clk), .rst_n(rst_loc_n), .d_i(run_i), .q_o(run_s)
  );
  clkgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_alt_sync (
    .clk(src_clk), .rst_n(rst_loc_n), .d_i(alt_i), .q_o(alt_s)
  );

  always_comb begin
    div_sel = alt_s ? div_alt_i : div_main_i;
    n_eff   = (div_sel == '0) ? DIV_W'(1) : div_sel;
    bypass  = (n_eff == DIV_W'(1));
    half    = n_eff >> 1;
    cnt_d   = (cnt_q >= n_eff - 1'b1) ? '0 : cnt_q + 1'b1;
    lvl_d   = (cnt_d < half);
    lvl_now = bypass ? 1'b0 : lvl_q;
  end

  always_ff @(posedge src_clk or negedge rst_loc_n) begin
    if (!rst_loc_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  // enable may change only on a falling source edge while the divided level is low
  always_ff @(negedge src_clk or negedge rst_loc_n) begin
    if (!rst_loc_n)    en_q <= 1'b0;
    else if (!lvl_now) en_q <= run_s;
  end

  assign clk_o = (bypass ? src_clk : lvl_q) & en_q;
endmodule

// File: rtl/clkgen_out_ctrl.sv
module clkgen_out_ctrl
  import clkgen_pkg::*;
#(
  parameter int NOUT        = 3,
  parameter int NPLL        = 3,
  parameter int DIV_W       = 8,
  parameter int LOCK_W      = 12,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NPLL + 1),
  localparam int CFG_W      = 2 + NOUT + LOCK_W + NOUT * (SEL_W + DIV_W) + DIV_W
) (
  input  logic             ref_clk,
  input  logic [NPLL-1:0]  pll_clk_i,
  input  logic             rst_n,
  input  logic             ctl_pin_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [NOUT-1:0]  clk_o,
  output logic [NOUT-1:0]  drv_en_o,
  output logic             pll_pd_o,
  output logic             busy_o
);
  localparam int MASK_LO = 2;
  localparam int LOCK_LO = MASK_LO + NOUT;
  localparam int OUT_LO  = LOCK_LO + LOCK_W;
  localparam int OUT_W   = SEL_W + DIV_W;
  localparam int ALT_LO  = OUT_LO + NOUT * OUT_W;

  logic              rst_ref_n;
  logic [CFG_W-1:0]  cfg_q;
  ctl_mode_e         mode_q;
  logic [NOUT-1:0]   mask_q;
  logic [LOCK_W-1:0] lock_len;
  logic [DIV_W-1:0]  div_alt;
  logic [NOUT-1:0]   run_vec;
  logic              alt_a;
  logic [LOCK_W-1:0] lock_cnt;

  clkgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ref_rst_sync (
    .clk(ref_clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_ref_n)
  );

  // configuration is captured only while the reference domain is held in reset
  always_ff @(posedge ref_clk) begin
    if (!rst_ref_n) cfg_q <= cfg_i;
  end

  assign mode_q   = ctl_mode_e'(cfg_q[1:0]);
  assign mask_q   = cfg_q[MASK_LO +: NOUT];
  assign lock_len = cfg_q[LOCK_LO +: LOCK_W];
  assign div_alt  = cfg_q[ALT_LO +: DIV_W];

  clkgen_ctrl #(.NOUT(NOUT), .LOCK_W(LOCK_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .ref_clk     (ref_clk),
    .rst_n       (rst_ref_n),
    .pin_i       (ctl_pin_i),
    .mode_i      (mode_q),
    .susp_mask_i (mask_q),
    .lock_len_i  (lock_len),
    .drv_en_o    (drv_en_o),
    .pll_pd_o    (pll_pd_o),
    .busy_o      (busy_o),
    .run_o       (run_vec),
    .alt_o       (alt_a),
    .lock_cnt_o  (lock_cnt)
  );

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div_main;
    logic [DIV_W-1:0] div_second;
    logic             alt_sel;
    logic             src_clk;

    assign sel      = cfg_q[OUT_LO + g * OUT_W +: SEL_W];
    assign div_main = cfg_q[OUT_LO + g * OUT_W + SEL_W +: DIV_W];

    if (g == 0) begin : g_alt
      assign div_second = div_alt;
      assign alt_sel    = alt_a;
    end else begin : g_noalt
      assign div_second = div_main;
      assign alt_sel    = 1'b0;
    end

    always_comb begin
      src_clk = ref_clk;
      for (int k = 0; k < NPLL; k++) begin
        if (sel == SEL_W'(k + 1)) src_clk = pll_clk_i[k];
      end
    end

    clkgen_out_path #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_path (
      .src_clk    (src_clk),
      .rst_n      (rst_n),
      .run_i      (run_vec[g]),
      .alt_i      (alt_sel),
      .div_main_i (div_main),
      .div_alt_i  (div_second),
      .clk_o      (clk_o[g])
    );
  end
endmodule

// File: rtl/clkgen_out_ctrl_chk.sv
module clkgen_out_ctrl_chk
  import clkgen_pkg::*;
#(
  parameter int NOUT   = 3,
  parameter int LOCK_W = 12
) (
  input logic              ref_clk,
  input logic              rst_n,
  input ctl_mode_e         mode,
  input logic [NOUT-1:0]   mask,
  input logic [NOUT-1:0]   drv,
  input logic              pll_pd,
  input logic              busy,
  input logic [NOUT-1:0]   run,
  input logic              alt,
  input logic [LOCK_W-1:0] cnt
);
  AST_DRV_FULL_OUTSIDE_OE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (mode != CTL_OE) |=> (drv == {NOUT{1'b1}})); // R2
  AST_DRV_UNIFORM: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (drv == '0) || (drv == {NOUT{1'b1}})); // R2
  AST_PD_ONLY_IN_PD_MODE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (mode != CTL_PWRDN) |=> !pll_pd); // R3
  AST_PD_IMPLIES_BUSY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pll_pd |-> busy); // R4
  AST_BUSY_HOLDS_RUN: assert property (@(posedge ref_clk) disable iff (!rst_n)
    busy |=> (run == '0)); // R4
  AST_LOCK_COUNTDOWN: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!pll_pd && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R4
  AST_ALT_ONLY_FSEL: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (mode != CTL_FSEL) |-> !alt); // R5
  AST_UNMASKED_RUN: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (mode == CTL_SUSP) |=> ((run & ~mask) == ({NOUT{!$past(busy)}} & ~mask))); // R6
endmodule

bind clkgen_out_ctrl clkgen_out_ctrl_chk #(.NOUT(NOUT), .LOCK_W(LOCK_W)) u_chk (
  .ref_clk (ref_clk),
  .rst_n   (rst_ref_n),
  .mode    (mode_q),
  .mask    (mask_q),
  .drv     (drv_en_o),
  .pll_pd  (pll_pd_o),
  .busy    (busy_o),
  .run     (run_vec),
  .alt     (alt_a),
  .cnt     (lock_cnt)
);

// File: tb/tb_clkgen_out_ctrl.sv
`timescale 1ns/1ps
module tb_clkgen_out_ctrl;
  localparam real REF_PERIOD = 20.0;
  localparam real PLL0_PER   = 8.0;
  localparam real PLL1_PER   = 12.0;
  localparam real PLL2_PER   = 6.0;
  localparam int  CFG_W      = 55;

  logic             ref_clk = 1'b0;
  logic [2:0]       pll_clk = 3'b000;
  logic             rst_n;
  logic             ctl_pin;
  logic [CFG_W-1:0] cfg;
  logic [2:0]       clk_o;
  logic [2:0]       drv_en_o;
  logic             pll_pd_o;
  logic             busy_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(REF_PERIOD / 2.0) ref_clk = ~ref_clk;
  initial begin #1.3; forever #(PLL0_PER / 2.0) pll_clk[0] = ~pll_clk[0]; end
  initial begin #2.1; forever #(PLL1_PER / 2.0) pll_clk[1] = ~pll_clk[1]; end
  initial begin #0.7; forever #(PLL2_PER / 2.0) pll_clk[2] = ~pll_clk[2]; end

  clkgen_out_ctrl dut (
    .ref_clk(ref_clk), .pll_clk_i(pll_clk), .rst_n(rst_n), .ctl_pin_i(ctl_pin),
    .cfg_i(cfg), .clk_o(clk_o), .drv_en_o(drv_en_o), .pll_pd_o(pll_pd_o), .busy_o(busy_o)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [CFG_W-1:0] mk_cfg(int mode, int mask, int lock,
      int s0, int d0, int s1, int d1, int s2, int d2, int alt);
    logic [CFG_W-1:0] c;
    c = '0;
    c[1:0]   = mode[1:0];
    c[4:2]   = mask[2:0];
    c[16:5]  = lock[11:0];
    c[18:17] = s0[1:0]; c[26:19] = d0[7:0];
    c[28:27] = s1[1:0]; c[36:29] = d1[7:0];
    c[38:37] = s2[1:0]; c[46:39] = d2[7:0];
    c[54:47] = alt[7:0];
    return c;
  endfunction

  // ---------------- behavioural reference model (reference domain) --------
  int m_mode, m_lock;
  int m_rel;
  bit m_hist[$];
  bit m_pd;
  int m_cnt;
  int m_drv;
  bit cmp_en = 0;

  always @(posedge ref_clk) begin
    if (!rst_n) begin
      m_rel = 0; m_hist = {1'b1, 1'b1}; m_pd = 1; m_cnt = 0; m_drv = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit ps;
      ps = m_hist[1];
      m_hist.push_front(ctl_pin);
      void'(m_hist.pop_back());
      if (m_pd) m_cnt = m_lock;
      else if (m_cnt > 0) m_cnt--;
      m_pd  = (m_mode == 1) && !ps;
      m_drv = ((m_mode != 0) || ps) ? 7 : 0;
    end
  end

  always @(negedge ref_clk) begin
    if (cmp_en) begin
      check(drv_en_o == 3'(m_drv), "R2", "drive enables vs model", drv_en_o, m_drv);
      check(pll_pd_o == m_pd, "R3", "pll power-down vs model", pll_pd_o, m_pd);
      check(busy_o == (m_pd || m_cnt != 0), "R4", "busy vs model", busy_o, int'(m_pd || m_cnt != 0));
    end
  end

  // ---------------- output clock monitors --------------------------------
  int  rises[3];
  real t_rise[3];
  real per_m[3];
  real hi_m[3];
  real exp_hi[3];
  bit  arm[3];

  for (genvar g = 0; g < 3; g++) begin : g_mon
    initial begin rises[g] = 0; t_rise[g] = -1.0; per_m[g] = 0.0; hi_m[g] = 0.0; arm[g] = 0; end
    always @(posedge clk_o[g]) begin
      if (t_rise[g] >= 0.0) per_m[g] = $realtime - t_rise[g];
      t_rise[g] = $realtime;
      rises[g]++;
    end
    always @(negedge clk_o[g]) begin
      hi_m[g] = $realtime - t_rise[g];
      if (arm[g]) begin
        real d;
        d = hi_m[g] - exp_hi[g];
        check(d < 0.5 && d > -0.5, "R9", $sformatf("full-width pulse on output %0d (ps)", g),
              int'(hi_m[g] * 1000.0), int'(exp_hi[g] * 1000.0));
      end
    end
  end

  task automatic chk_clk(int g, real per, real hi, string req);
    real dp, dh;
    dp = per_m[g] - per;
    dh = hi_m[g] - hi;
    check(dp < 0.5 && dp > -0.5, req, $sformatf("period output %0d (ps)", g),
          int'(per_m[g] * 1000.0), int'(per * 1000.0));
    check(dh < 0.5 && dh > -0.5, req, $sformatf("high time output %0d (ps)", g),
          int'(hi_m[g] * 1000.0), int'(hi * 1000.0));
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic do_reset(int mode, int lock, logic [CFG_W-1:0] c, bit pin);
    for (int g = 0; g < 3; g++) arm[g] = 0;
    @(negedge ref_clk);
    rst_n = 0;
    cfg = c; m_mode = mode; m_lock = lock; ctl_pin = pin;
    cycles(6);
    // R10: reset state
    check(drv_en_o == 3'b000, "R10", "drive enables in reset", drv_en_o, 0);
    check(pll_pd_o == 1'b1, "R10", "pll power-down in reset", pll_pd_o, 1);
    check(busy_o == 1'b1, "R10", "busy in reset", busy_o, 1);
    for (int k = 0; k < 4; k++) begin
      #(REF_PERIOD / 8.0);
      check(clk_o == 3'b000, "R10", "outputs low in reset", clk_o, 0);
    end
    @(negedge ref_clk);
    rst_n = 1;
  endtask

  task automatic wait_lock(string req);
    int snap[3];
    for (int g = 0; g < 3; g++) snap[g] = rises[g];
    while (busy_o) @(negedge ref_clk);
    for (int g = 0; g < 3; g++)
      check(rises[g] == snap[g], req, $sformatf("no rising edge while busy, output %0d", g), rises[g], snap[g]);
  endtask

  task automatic arm_all(real h0, real h1, real h2);
    exp_hi[0] = h0; exp_hi[1] = h1; exp_hi[2] = h2;
    for (int g = 0; g < 3; g++) arm[g] = 1;
  endtask

  initial begin
    int snap[3];
    rst_n = 0; ctl_pin = 1; cfg = '0; m_mode = 0; m_lock = 0;
    cycles(3);
    cmp_en = 1;

    // Phase 1: drive-enable mode, lock 5. A=pll0/4, B=ref/1, C=pll2/3
    do_reset(0, 5, mk_cfg(0, 0, 5, 1, 4, 0, 1, 3, 3, 2), 1'b1);
    wait_lock("R4");
    cycles(15);
    arm_all(16.0, 10.0, 6.0);
    cycles(60);
    chk_clk(0, 32.0, 16.0, "R7 R8");
    chk_clk(1, 20.0, 10.0, "R7 R8");
    chk_clk(2, 18.0, 6.0, "R8");
    ctl_pin = 0;
    cycles(6);
    check(drv_en_o == 3'b000, "R2", "drive enables clear on low pin", drv_en_o, 0);
    for (int g = 0; g < 3; g++) snap[g] = rises[g];
    cycles(20);
    for (int g = 0; g < 3; g++)
      check(rises[g] > snap[g], "R2", $sformatf("output %0d keeps toggling in high-Z", g), rises[g], snap[g] + 1);
    ctl_pin = 1;
    cycles(6);
    check(drv_en_o == 3'b111, "R2", "drive enables set on high pin", drv_en_o, 7);

    // Phase 2: suspend mode, mask 101, lock 3. A=pll1/2, B=pll0/0, C=ref/2
    do_reset(3, 3, mk_cfg(3, 5, 3, 2, 2, 1, 0, 0, 2, 1), 1'b1);
    wait_lock("R4");
    cycles(15);
    arm_all(12.0, 4.0, 20.0);
    cycles(40);
    chk_clk(0, 24.0, 12.0, "R8");
    chk_clk(1, 8.0, 4.0, "R8");
    chk_clk(2, 40.0, 20.0, "R7");
    check(drv_en_o == 3'b111, "R2", "drive enables outside drive-enable mode", drv_en_o, 7);
    ctl_pin = 0;
    cycles(30);
    for (int g = 0; g < 3; g++) snap[g] = rises[g];
    cycles(40);
    check(rises[0] == snap[0], "R6", "masked output A suspended", rises[0], snap[0]);
    check(rises[2] == snap[2], "R6", "masked output C suspended", rises[2], snap[2]);
    check(rises[1] > snap[1], "R6", "unmasked output B running", rises[1], snap[1] + 1);
    check(clk_o[0] == 1'b0 && clk_o[2] == 1'b0, "R9", "suspended outputs rest low", {clk_o[2], clk_o[0]}, 0);
    check(busy_o == 1'b0, "R6", "suspend leaves busy low", busy_o, 0);
    ctl_pin = 1;
    cycles(40);
    chk_clk(0, 24.0, 12.0, "R6");
    chk_clk(2, 40.0, 20.0, "R6");

    // Phase 3: power-down mode, lock 10. A=ref/6, B=pll1/1, C=pll2/5
    do_reset(1, 10, mk_cfg(1, 0, 10, 0, 6, 2, 1, 3, 5, 1), 1'b1);
    wait_lock("R4");
    cycles(15);
    arm_all(60.0, 6.0, 12.0);
    cycles(60);
    chk_clk(0, 120.0, 60.0, "R8");
    chk_clk(1, 12.0, 6.0, "R8");
    chk_clk(2, 30.0, 12.0, "R8");
    ctl_pin = 0;
    cycles(4);
    check(pll_pd_o == 1'b1, "R3", "power-down request raised", pll_pd_o, 1);
    cycles(20);
    for (int g = 0; g < 3; g++) snap[g] = rises[g];
    cycles(30);
    for (int g = 0; g < 3; g++)
      check(rises[g] == snap[g], "R3", $sformatf("output %0d stopped in power-down", g), rises[g], snap[g]);
    check(clk_o == 3'b000, "R3", "outputs low in power-down", clk_o, 0);
    ctl_pin = 1;
    for (int g = 0; g < 3; g++) snap[g] = rises[g];
    cycles(5);
    check(busy_o == 1'b1, "R4", "busy during re-lock", busy_o, 1);
    wait_lock("R4");
    cycles(60);
    chk_clk(0, 120.0, 60.0, "R4");
    chk_clk(2, 30.0, 12.0, "R4");

    // Phase 4: frequency select, lock 0. A=pll2/2 alt 5, B=pll0/3, C=pll1/4
    do_reset(2, 0, mk_cfg(2, 0, 0, 3, 2, 1, 3, 2, 4, 5), 1'b0);
    wait_lock("R4");
    cycles(15);
    arm_all(6.0, 8.0, 24.0);
    cycles(40);
    chk_clk(0, 12.0, 6.0, "R5");
    chk_clk(1, 24.0, 8.0, "R5");
    chk_clk(2, 48.0, 24.0, "R5");
    arm[0] = 0;
    ctl_pin = 1;
    cycles(20);
    exp_hi[0] = 12.0; arm[0] = 1;
    cycles(30);
    chk_clk(0, 30.0, 12.0, "R5");
    chk_clk(1, 24.0, 8.0, "R5");
    chk_clk(2, 48.0, 24.0, "R5");
    arm[0] = 0;
    ctl_pin = 0;
    cycles(20);
    exp_hi[0] = 6.0; arm[0] = 1;
    cycles(20);
    chk_clk(0, 12.0, 6.0, "R5");

    // R1: configuration change outside reset has no effect
    cfg = mk_cfg(0, 7, 0, 0, 9, 0, 9, 0, 9, 9);
    ctl_pin = 0;
    cycles(40);
    check(drv_en_o == 3'b111, "R1", "late mode change ignored", drv_en_o, 7);
    chk_clk(0, 12.0, 6.0, "R1");
    chk_clk(2, 48.0, 24.0, "R1");

    for (int g = 0; g < 3; g++) arm[g] = 0;
    cmp_en = 0;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule